// File: doc/BRIEF.md
# Dual-Channel Wiper Register Slave on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C). It holds two 8-bit wiper settings, a shutdown flag and two general-purpose output latches. The bus lines come in as plain samples from a system clock that runs many times faster than the bus clock. Both lines pass through a two-flop synchronizer. Start and stop are taken as edges on the data line while the bus clock is high. The block drives the data line low only to acknowledge a byte or to shift out a zero during a read.

A write is always three bytes long: an address byte, a control byte and a value byte. The control byte picks one of the two channels. It can also ask for a reload of the channel to the midpoint code, and it carries the shutdown request and the two output-pin levels. The chosen wiper changes only once the value byte has been received in full and its acknowledge clock has ended. A read is an address byte followed by one byte from the channel that the most recent control byte picked.

Top module: `wpot_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal binary 01011 followed by strap_addr[1] and then strap_addr[0]. Bit 0 of the address byte selects the direction: 0 means write, 1 means read. On any other address it never pulls the data line low during that frame.
- R2: In a write, the block acknowledges the address byte, the control byte and the value byte. After the acknowledge clock of the value byte ends, the chosen channel takes the value byte. The value byte is sent MSB first.
- R3: Control byte fields: bit 7 is the channel (0 selects wiper_a, 1 selects wiper_b), bit 6 is the midpoint reload, bit 5 is shutdown, bit 4 is output pin 1 and bit 3 is output pin 2. Bits 2 to 0 have no effect on any output.
- R4: When bit 6 of the control byte is 1, the chosen channel is loaded with 0x80 and the value byte is discarded.
- R5: shutdown, out_pin1 and out_pin2 take bits 5, 4 and 3 of every control byte whose acknowledge clock has completed, even if the frame ends before the value byte.
- R6: A read returns the wiper of the channel picked by the last control byte, MSB first. The block releases the data line in the master's acknowledge slot.
- R7: A stop or a repeated start before the value byte's acknowledge clock has ended leaves both wipers unchanged.
- R8: After reset, both wipers hold 0x80, shutdown and both output pins are 0, the read channel is wiper_a and the data line is released.
- R9: Any byte that follows the value byte in the same write frame is not acknowledged and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line (wired-AND level) |
| strap_addr | input | 2 | Strapped low two bits of the 7-bit address |
| sda_pull_low | output | 1 | 1 pulls the data line low |
| wiper_a | output | 8 | Channel 1 wiper setting |
| wiper_b | output | 8 | Channel 2 wiper setting |
| shutdown | output | 1 | Shutdown request latch |
| out_pin1 | output | 1 | General-purpose output latch 1 |
| out_pin2 | output | 1 | General-purpose output latch 2 |

## Verification
The assertions assume a well-formed bus. The data line changes only while the bus clock is low, except for start and stop. Each bus phase lasts longer than the synchronizer and edge-detection delay, so the frame engine sees clock edges in their true order. The bench drives each bus quarter-period for four system clocks and moves data only during the low phase of the clock. It forms the data line as the AND of its own drive and the block's pull-down, so it keeps within those limits. It sweeps all 128 addresses under each of the four strap settings, and it sweeps value bytes over both channels with varying don't-care and latch bits.

// File: rtl/wpot_pkg.sv
package wpot_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam int NUM_CH = 2;
    localparam logic [4:0]        ADDR_FIXED = 5'b01011;
    localparam logic [BYTE_W-1:0] MIDPOINT   = 8'h80;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_VAL,
        ST_VAL_ACK,
        ST_RD_BIT,
        ST_RD_ACK
    } phase_e;

    // control byte as received, MSB first
    typedef struct packed {
        logic       ch;
        logic       reload;
        logic       sd;
        logic       p1;
        logic       p2;
        logic [2:0] spare;
    } ctrl_byte_t;

    typedef struct packed {
        logic ch;
        logic reload;
        logic sd;
        logic p1;
        logic p2;
    } ctl_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [6:0] a, input logic [1:0] strap);
        return a == {ADDR_FIXED, strap};
    endfunction

endpackage

// File: rtl/wpot_sync.sv
module wpot_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/wpot_bus_cond.sv
module wpot_bus_cond import wpot_pkg::*; (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.sda   = sda_s;
    end
endmodule

// File: rtl/wpot_frame_fsm.sv
module wpot_frame_fsm import wpot_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [1:0]        strap,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_low,
    output logic              ctl_en,
    output ctl_t              ctl,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    phase_e            state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              got, rd_mode;
    ctrl_byte_t        cb;

    assign cb = ctrl_byte_t'(shreg);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            got     <= 1'b0;
            rd_mode <= 1'b0;
            ctl_en  <= 1'b0;
            ctl     <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            ctl_en <= 1'b0;
            wr_en  <= 1'b0;
            if (ev.start) begin
                state <= ST_ADDR;
                cnt   <= '0;
                got   <= 1'b0;
            end else if (ev.stop) begin
                state <= ST_IDLE;
                got   <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_CTRL, ST_VAL: begin
                        if (ev.rise) begin
                            shreg <= {shreg[BYTE_W-2:0], ev.sda};
                            cnt   <= cnt + 1'b1;
                            if (cnt == LAST) got <= 1'b1;
                        end else if (ev.fall && got) begin
                            got <= 1'b0;
                            if (state == ST_ADDR) begin
                                if (addr_hit(shreg[7:1], strap)) begin
                                    state   <= ST_ADDR_ACK;
                                    rd_mode <= shreg[0];
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_CTRL) begin
                                state <= ST_CTRL_ACK;
                            end else begin
                                state <= ST_VAL_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: if (ev.fall) begin
                        cnt <= '0;
                        if (rd_mode) begin
                            state <= ST_RD_BIT;
                            shreg <= rd_byte;
                        end else begin
                            state <= ST_CTRL;
                        end
                    end
                    ST_CTRL_ACK: if (ev.fall) begin
                        ctl    <= '{ch: cb.ch, reload: cb.reload, sd: cb.sd, p1: cb.p1, p2: cb.p2};
                        ctl_en <= 1'b1;
                        cnt    <= '0;
                        state  <= ST_VAL;
                    end
                    ST_VAL_ACK: if (ev.fall) begin
                        wr_en   <= 1'b1;
                        wr_data <= shreg;
                        state   <= ST_IDLE;
                    end
                    ST_RD_BIT: if (ev.fall) begin
                        if (cnt == LAST) begin
                            state <= ST_RD_ACK;
                        end else begin
                            shreg <= {shreg[BYTE_W-2:0], 1'b0};
                            cnt   <= cnt + 1'b1;
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.rise && ev.sda) begin
                            state <= ST_IDLE;
                        end else if (ev.fall) begin
                            state <= ST_RD_BIT;
                            shreg <= rd_byte;
                            cnt   <= '0;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign sda_low = (state == ST_ADDR_ACK) || (state == ST_CTRL_ACK) ||
                     (state == ST_VAL_ACK) || ((state == ST_RD_BIT) && !shreg[BYTE_W-1]);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_low);

    a_r6_master_slot_free: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_ACK) |-> !sda_low);

    a_r7_commit_after_val_ack: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($past(state) == ST_VAL_ACK) && !ctl_en);

    a_r5_ctl_after_ctl_ack: assert property (@(posedge clk) disable iff (rst)
        ctl_en |-> ($past(state) == ST_CTRL_ACK) && (state == ST_VAL));
endmodule

// File: rtl/wpot_wipers.sv
module wpot_wipers import wpot_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_en,
    input  ctl_t              ctl,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] wiper [NUM_CH],
    output logic [BYTE_W-1:0] rd_byte,
    output logic              sd_q,
    output logic              p1_q,
    output logic              p2_q
);
    logic sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel  <= 1'b0;
            sd_q <= 1'b0;
            p1_q <= 1'b0;
            p2_q <= 1'b0;
        end else if (ctl_en) begin
            sel  <= ctl.ch;
            sd_q <= ctl.sd;
            p1_q <= ctl.p1;
            p2_q <= ctl.p2;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)
                wiper[c] <= MIDPOINT;
            else if (wr_en && (ctl.ch == 1'(c)))
                wiper[c] <= ctl.reload ? MIDPOINT : wr_data;
        end
    end

    assign rd_byte = wiper[sel];

    a_r7_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(wiper[0]) && $stable(wiper[1]));

    a_r4_reload_a: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ctl.reload && !ctl.ch) |=> (wiper[0] == MIDPOINT) && $stable(wiper[1]));

    a_r4_reload_b: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ctl.reload && ctl.ch) |=> (wiper[1] == MIDPOINT) && $stable(wiper[0]));
endmodule

// File: rtl/wpot_slave.sv
module wpot_slave import wpot_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [1:0] strap_addr,
    output logic       sda_pull_low,
    output logic [7:0] wiper_a,
    output logic [7:0] wiper_b,
    output logic       shutdown,
    output logic       out_pin1,
    output logic       out_pin2
);
    logic [1:0]        lines_s;
    bus_ev_t           ev;
    logic              ctl_en, wr_en;
    ctl_t              ctl;
    logic [BYTE_W-1:0] wr_data, rd_byte;
    logic [BYTE_W-1:0] wiper [NUM_CH];

    wpot_sync #(.STAGES(2), .W(2)) u_sync (
        .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(lines_s)
    );

    wpot_bus_cond u_cond (
        .clk(clk), .rst(rst), .scl_s(lines_s[1]), .sda_s(lines_s[0]), .ev(ev)
    );

    wpot_frame_fsm u_fsm (
        .clk(clk), .rst(rst), .ev(ev), .strap(strap_addr), .rd_byte(rd_byte),
        .sda_low(sda_pull_low), .ctl_en(ctl_en), .ctl(ctl),
        .wr_en(wr_en), .wr_data(wr_data)
    );

    wpot_wipers u_regs (
        .clk(clk), .rst(rst), .ctl_en(ctl_en), .ctl(ctl), .wr_en(wr_en),
        .wr_data(wr_data), .wiper(wiper), .rd_byte(rd_byte),
        .sd_q(shutdown), .p1_q(out_pin1), .p2_q(out_pin2)
    );

    assign wiper_a = wiper[0];
    assign wiper_b = wiper[1];

    a_r8_no_pull_in_reset: assert property (@(posedge clk)
        $past(rst) |-> !sda_pull_low);
endmodule

// File: tb/wpot_slave_tb_top.sv
module wpot_slave_tb_top;
    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] strap = 2'b00;
    logic       sda_pull_low, shutdown, out_pin1, out_pin2;
    logic [7:0] wiper_a, wiper_b;
    logic       sda_line;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    logic [7:0] m_w [2];
    logic       m_sel, m_sd, m_p1, m_p2;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull_low;

    wpot_slave dut_i (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .strap_addr(strap),
        .sda_pull_low(sda_pull_low), .wiper_a(wiper_a), .wiper_b(wiper_b),
        .shutdown(shutdown), .out_pin1(out_pin1), .out_pin2(out_pin2)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq(); scl_m = 1'b1; waitq();
        sda_m = 1'b0; waitq(); scl_m = 1'b0; waitq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq(); scl_m = 1'b1; waitq();
        sda_m = 1'b1; waitq(); waitq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; waitq(); scl_m = 1'b1; waitq(); waitq(); scl_m = 1'b0; waitq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; waitq(); scl_m = 1'b1; waitq();
        ack = ~sda_line; waitq(); scl_m = 1'b0; waitq();
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            waitq(); scl_m = 1'b1; waitq(); b = {b[6:0], sda_line}; waitq(); scl_m = 1'b0; waitq();
        end
        sda_m = ~m_ack; waitq(); scl_m = 1'b1; waitq(); waitq(); scl_m = 1'b0; waitq();
    endtask

    function automatic logic [7:0] my_addr(input logic rw);
        return {5'b01011, strap, rw};
    endfunction

    task automatic model_ctl(input logic [7:0] c);
        m_sel = c[7]; m_sd = c[5]; m_p1 = c[4]; m_p2 = c[3];
    endtask

    task automatic check_outputs(input string req);
        chk(req, wiper_a, m_w[0]);
        chk(req, wiper_b, m_w[1]);
        chk(req, {shutdown, out_pin1, out_pin2}, {m_sd, m_p1, m_p2});
    endtask

    task automatic wr_frame(input logic [7:0] c, input logic [7:0] d);
        logic a0, a1, a2;
        bus_start();
        send_byte(my_addr(1'b0), a0);
        send_byte(c, a1);
        send_byte(d, a2);
        bus_stop();
        chk("R2 write acks", {a0, a1, a2}, 3'b111);
        model_ctl(c);
        m_w[c[7]] = c[6] ? 8'h80 : d;
    endtask

    task automatic rd_frame(input string req);
        logic a0;
        logic [7:0] v;
        bus_start();
        send_byte(my_addr(1'b1), a0);
        recv_byte(1'b0, v);
        bus_stop();
        chk({req, " read ack"}, a0, 1);
        chk({req, " read data"}, v, m_w[m_sel]);
    endtask

    initial begin
        repeat (200000 - 5000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic a0, a1, a2, a3;
        logic [7:0] c, d;
        m_w[0] = 8'h80; m_w[1] = 8'h80; m_sel = 0; m_sd = 0; m_p1 = 0; m_p2 = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R8 reset state
        check_outputs("R8 reset");
        chk("R8 released", sda_pull_low, 0);
        rd_frame("R8 default channel");

        // R1 address sweep under every strap setting
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            for (int a = 0; a < 128; a++) begin
                bus_start();
                send_byte({7'(a), 1'b0}, a0);
                bus_stop();
                chk("R1 address match", a0, (a == {5'b01011, 2'(s)}) ? 1 : 0);
            end
        end
        strap = 2'b10;

        // R2 R3 R5 R6 value sweep over both channels, spare bits varied
        for (int ch = 0; ch < 2; ch++) begin
            for (int i = 0; i < 16; i++) begin
                d = 8'((i * 53 + ch * 29 + 7) & 255);
                c = {1'(ch), 1'b0, 1'(i), 1'(i >> 1), 1'(i >> 2), 3'(i * 5)};
                wr_frame(c, d);
                check_outputs("R2 R3 R5 wiper update");
                rd_frame("R6");
            end
        end

        // R4 midpoint reload discards value byte
        wr_frame(8'h20, 8'h11);
        wr_frame(8'hC0, 8'h33);
        check_outputs("R4 reload channel b");
        wr_frame(8'h40, 8'hEE);
        check_outputs("R4 reload channel a");

        // R7 R5 stop after control byte: latches update, wipers do not
        wr_frame(8'h00, 8'h5A);
        bus_start();
        send_byte(my_addr(1'b0), a0);
        send_byte(8'hB8, a1);
        bus_stop();
        model_ctl(8'hB8);
        check_outputs("R7 R5 stop after control");
        rd_frame("R7 selection moved");

        // R7 repeated start inside value byte
        bus_start();
        send_byte(my_addr(1'b0), a0);
        send_byte(8'h08, a1);
        send_bits(8'hFF, 4);
        model_ctl(8'h08);
        rd_frame("R7 repeated start");
        check_outputs("R7 repeated start");

        // R9 extra byte after the value byte
        bus_start();
        send_byte(my_addr(1'b0), a0);
        send_byte(8'h90, a1);
        send_byte(8'h6C, a2);
        send_byte(8'h01, a3);
        bus_stop();
        model_ctl(8'h90);
        m_w[1] = 8'h6C;
        chk("R9 extra byte not acked", {a0, a1, a2, a3}, 4'b1110);
        check_outputs("R9 extra byte ignored");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule